// File: doc/BRIEF.md
# Sign-Magnitude Adder/Subtractor

This block takes two signed operands held in sign-magnitude form and returns their sum or difference in the same form. It has no clock. One control input chooses between addition and subtraction. Subtraction is done by inverting the sign of the second operand. After that inversion, the block looks at the two effective signs. If the signs match, it adds the two magnitudes and keeps the shared sign. If they differ, it compares the magnitudes, subtracts the smaller from the larger, and gives the result the sign of the operand with the larger magnitude.

Both encodings of zero are accepted on input and behave the same way. Any zero result is always given as the all-zero word. If adding two same-sign magnitudes carries out of the magnitude field, the block raises an overflow flag, and the result word then has no defined value.

Top module: `sm_addsub`

## Requirements
- R1: An operand word has its sign in bit WIDTH-1 (0 means positive or zero, 1 means negative) and its magnitude in bits WIDTH-2..0. The result word uses the same layout.
- R2: When `sub_i` is 0 the block computes X + Y. When `sub_i` is 1 it computes X - Y by inverting the sign bit of Y before any other decision is made.
- R3: When the effective signs match and the magnitude sum fits in WIDTH-1 bits, the result magnitude is the sum and the result sign is the shared sign, with `ovf_o` = 0.
- R4: When the effective signs match and the magnitude sum exceeds 2^(WIDTH-1)-1, `ovf_o` is 1.
- R5: When the effective signs differ and |X| > |Y|, the result is |X| - |Y| with the sign of X.
- R6: When the effective signs differ and |Y| > |X|, the result is |Y| - |X| with the effective sign of Y.
- R7: A result with zero magnitude is always output as +0 (all bits 0). This includes equal magnitudes with opposite effective signs.
- R8: An input of -0 (sign 1, magnitude 0) gives exactly the same output as +0 in the same position.
- R9: `ovf_o` is 0 whenever the effective signs differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | Operand X, sign-magnitude |
| opb_i | input | WIDTH | Operand Y, sign-magnitude |
| sub_i | input | 1 | 0 = add, 1 = subtract Y from X |
| sum_o | output | WIDTH | Result, sign-magnitude |
| ovf_o | output | 1 | Magnitude field overflow on a same-sign add |

## Verification
The bench builds the block with WIDTH = 4. This makes the input space small: 16 values of X, 16 values of Y and both operations, 512 cases in all. The bench applies every one of them and compares each against an integer model of the signed arithmetic. That sweep covers both zero encodings in both operand positions. It also covers every tie between magnitudes and every overflowing same-sign sum, so the zero rules and the overflow edge at 7 + 1 are checked directly rather than sampled.

// File: rtl/sm_addsub_pkg.sv
package sm_addsub_pkg;

    typedef enum logic {
        SM_OP_ADD = 1'b0,
        SM_OP_SUB = 1'b1
    } sm_op_e;

    // Decisions taken from the two sign bits and the magnitude comparison
    typedef struct packed {
        logic sx;       // sign of X
        logic sy_eff;   // sign of Y after the subtract inversion
        logic same;     // effective signs agree
        logic sign;     // sign chosen for the result before zero cleanup
    } sm_ctl_t;

endpackage

// File: rtl/sm_mag_cmp.sv
module sm_mag_cmp #(
    parameter int MW = 7
) (
    input  logic [MW-1:0] a_i,
    input  logic [MW-1:0] b_i,
    output logic          a_ge_b_o
);
    always_comb begin
        a_ge_b_o = (a_i >= b_i);
    end
endmodule

// File: rtl/sm_mag_unit.sv
module sm_mag_unit #(
    parameter int MW = 7
) (
    input  logic [MW-1:0] a_i,
    input  logic [MW-1:0] b_i,
    input  logic          add_i,
    input  logic          a_ge_b_i,
    output logic [MW-1:0] mag_o,
    output logic          carry_o
);
    logic [MW:0]   sum_w;
    logic [MW-1:0] big_w;
    logic [MW-1:0] small_w;
    logic [MW-1:0] diff_w;

    always_comb begin
        sum_w   = {1'b0, a_i} + {1'b0, b_i};
        big_w   = a_ge_b_i ? a_i : b_i;
        small_w = a_ge_b_i ? b_i : a_i;
        diff_w  = big_w - small_w;
        if (add_i) begin
            mag_o   = sum_w[MW-1:0];
            carry_o = sum_w[MW];
        end else begin
            mag_o   = diff_w;
            carry_o = 1'b0;
        end
    end
endmodule

// File: rtl/sm_result_pack.sv
module sm_result_pack #(
    parameter int WIDTH = 8,
    localparam int MW = WIDTH - 1
) (
    input  logic          sign_i,
    input  logic [MW-1:0] mag_i,
    output logic [WIDTH-1:0] word_o
);
    always_comb begin
        // A zero magnitude never carries a negative sign
        word_o = {sign_i & (|mag_i), mag_i};
    end
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
    import sm_addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             ovf_o
);
    localparam int MW = WIDTH - 1;

    logic [MW-1:0] mag_x;
    logic [MW-1:0] mag_y;
    logic          x_ge_y;
    logic [MW-1:0] mag_r;
    logic          carry_r;
    sm_op_e        op_w;
    sm_ctl_t       ctl_d;

    assign mag_x = opa_i[MW-1:0];
    assign mag_y = opb_i[MW-1:0];
    assign op_w  = sm_op_e'(sub_i);

    sm_mag_cmp #(.MW(MW)) u_cmp (
        .a_i      (mag_x),
        .b_i      (mag_y),
        .a_ge_b_o (x_ge_y)
    );

    always_comb begin
        ctl_d        = '0;
        ctl_d.sx     = opa_i[WIDTH-1];
        ctl_d.sy_eff = opb_i[WIDTH-1] ^ (op_w == SM_OP_SUB);
        ctl_d.same   = (ctl_d.sx == ctl_d.sy_eff);
        if (ctl_d.same) begin
            ctl_d.sign = ctl_d.sx;
        end else begin
            ctl_d.sign = x_ge_y ? ctl_d.sx : ctl_d.sy_eff;
        end
    end

    sm_mag_unit #(.MW(MW)) u_mag (
        .a_i      (mag_x),
        .b_i      (mag_y),
        .add_i    (ctl_d.same),
        .a_ge_b_i (x_ge_y),
        .mag_o    (mag_r),
        .carry_o  (carry_r)
    );

    sm_result_pack #(.WIDTH(WIDTH)) u_pack (
        .sign_i (ctl_d.sign),
        .mag_i  (mag_r),
        .word_o (sum_o)
    );

    assign ovf_o = carry_r;

endmodule

// File: rtl/sm_addsub_chk.sv
module sm_addsub_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic             sub_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             ovf_o
);
    localparam int MW = WIDTH - 1;

    logic          sx;
    logic          sy;
    logic [MW-1:0] mx;
    logic [MW-1:0] my;
    logic [MW:0]   msum;

    always_comb begin
        sx   = opa_i[WIDTH-1];
        sy   = opb_i[WIDTH-1] ^ sub_i;
        mx   = opa_i[MW-1:0];
        my   = opb_i[MW-1:0];
        msum = {1'b0, mx} + {1'b0, my};

        a_r9_no_ovf_mixed: assert ((sx == sy) || !ovf_o)
            else $error("R9 overflow raised with mixed signs");
        a_r7_plus_zero: assert ((|sum_o[MW-1:0]) || !sum_o[WIDTH-1] || ovf_o)
            else $error("R7 negative zero on output");
        a_r4_overflow: assert (!((sx == sy) && msum[MW]) || ovf_o)
            else $error("R4 overflow not flagged");
        a_r3_shared_sign: assert (!((sx == sy) && !msum[MW] && (|msum))
                                  || (sum_o[WIDTH-1] == sx && !ovf_o))
            else $error("R3 sign differs from shared sign");
        a_r5_sign_of_x: assert (!((sx != sy) && (mx > my)) || (sum_o[WIDTH-1] == sx))
            else $error("R5 result sign not X");
        a_r6_sign_of_y: assert (!((sx != sy) && (my > mx)) || (sum_o[WIDTH-1] == sy))
            else $error("R6 result sign not Y");
    end
endmodule

bind sm_addsub sm_addsub_chk #(.WIDTH(WIDTH)) u_chk (
    .opa_i (opa_i),
    .opb_i (opb_i),
    .sub_i (sub_i),
    .sum_o (sum_o),
    .ovf_o (ovf_o)
);

// File: tb/sim_sm_addsub.sv
`timescale 1ns/1ps
module sim_sm_addsub;
    localparam int W   = 4;
    localparam int MAG = (1 << (W - 1)) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         sub = 1'b0;
    logic [W-1:0] res;
    logic         ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    sm_addsub #(.WIDTH(W)) u0 (
        .opa_i (a),
        .opb_i (b),
        .sub_i (sub),
        .sum_o (res),
        .ovf_o (ovf)
    );

    function automatic int sm_val(input logic [W-1:0] w);
        int m;
        m = int'(w[W-2:0]);
        return w[W-1] ? -m : m;
    endfunction

    task automatic check_one(input logic [W-1:0] xa, input logic [W-1:0] yb,
                             input logic op);
        int xv, yv, s, am;
        logic [W-1:0] exp_w;
        logic exp_ovf;
        string tag;
        @(negedge clk);
        a = xa; b = yb; sub = op;
        @(posedge clk);
        #2;
        xv = sm_val(xa);
        yv = sm_val(yb);
        if (op) yv = -yv;
        s  = xv + yv;
        am = (s < 0) ? -s : s;
        exp_ovf = (am > MAG);
        exp_w = (s < 0) ? {1'b1, am[W-2:0]} : {1'b0, am[W-2:0]};
        // classify for the message
        if (xa[W-2:0] == 0 || yb[W-2:0] == 0) tag = "R8";
        else if (s == 0) tag = "R7";
        else if (exp_ovf) tag = "R4";
        else if ((xa[W-1] ^ yb[W-1] ^ op) == 1'b0) tag = op ? "R2/R3" : "R3";
        else if (xa[W-2:0] > yb[W-2:0]) tag = "R5/R9";
        else tag = "R6/R9";
        checks++;
        if (ovf !== exp_ovf) begin
            errors++;
            $display("FAIL %s ovf x=%b y=%b op=%b actual %b expected %b",
                     tag, xa, yb, op, ovf, exp_ovf);
        end else if (!exp_ovf) begin
            checks++;
            if (res !== exp_w) begin
                errors++;
                $display("FAIL %s (R1 layout) x=%b y=%b op=%b actual %b expected %b",
                         tag, xa, yb, op, res, exp_w);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // reset state: zero inputs give +0 and no overflow (R7)
        checks++;
        if (res !== '0 || ovf !== 1'b0) begin
            errors++;
            $display("FAIL R7 idle actual %b/%b expected 0000/0", res, ovf);
        end
        rst_n = 1'b1;
        // directed corners: -0 + -0 -> +0 (R7, R8), 7+1 overflow (R4), 3-3 -> +0 (R7)
        check_one(4'b1000, 4'b1000, 1'b0);
        check_one(4'b0111, 4'b0001, 1'b0);
        check_one(4'b0011, 4'b0011, 1'b1);
        check_one(4'b1101, 4'b0010, 1'b0);
        // exhaustive sweep
        for (int o = 0; o < 2; o++)
            for (int i = 0; i < (1 << W); i++)
                for (int j = 0; j < (1 << W); j++)
                    check_one(W'(i), W'(j), o[0]);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule